// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This block sits between a host register port and an external byte-wide EEPROM. The host uses it in two ways. It can move single bytes: it loads an address register and, for writes, a data register, then sets a request bit in the control register. The block runs one EEPROM transaction and clears the request bit when the transaction is done. It can also start a burst: the block walks the EEPROM as a list of records and streams each record's payload into device memory through a byte write strobe.

Each burst record has three parts:
- A count byte.
- A two-byte offset, low byte first.
- The payload, which is as many data bytes as the count says.

The memory address of each payload byte joins two parts. The upper bits come from a base register that the host sets. The lower 15 bits come from the offset held in the record, and this offset goes up by one for each payload byte. A count of zero ends the burst.

The block keeps track of the last EEPROM location it touched. A new burst starts at the location after that one. If nothing has been touched since reset, the burst starts at location zero.

The EEPROM side is a request/ready byte interface. The block raises `ee_req` and holds the address, direction and write data steady. The EEPROM answers with a one-cycle `ee_ready` pulse. On a read, `ee_rdata` is valid during that pulse.

Top module: `eep_loader`

## Requirements
- R1: After reset, every register reads zero, `ee_req` is low and `mem_we` is low. The register offsets are: control 0, address 1, data 2, base 3, burst 4. Unmapped offsets read zero.
- R2: Writing the control register with bit 0 set writes the low 8 bits of the data register to the EEPROM location held in the address register. Control bit 0 reads 1 until the write completes, then reads 0.
- R3: Writing the control register with only bit 1 set reads the EEPROM location held in the address register. The byte is stored in the data register, zero-extended, and it is valid once control bit 1 reads 0 again.
- R4: If control bits 0 and 1 are written together, only the write is performed.
- R5: Control bit 2 reads 1 while any operation is in progress. While it is 1, every host register write is ignored, including new requests and writes to the address, data and base registers.
- R6: Writing burst register bit 0 starts a burst. That bit reads 1 while the burst runs and returns to 0 by itself when the burst ends.
- R7: A burst starts at EEPROM location 0 if no EEPROM location has been accessed since reset. Otherwise it starts at the location after the last one accessed, wrapping at the top of the EEPROM.
- R8: A burst reads records of the form {count, offset low, offset high, count data bytes}. Each data byte produces exactly one `mem_we` pulse carrying that byte. A count byte of zero ends the burst. During a burst the EEPROM is only read.
- R9: The memory address of a data byte is {base[8:0], offset[14:0]}. Bit 7 of the offset-high byte is ignored, and the offset increases by one for each data byte in the record.
- R10: In the default configuration, the offset wraps from 0x7FFF to 0x0000 without changing the base bits.
- R11: Every byte read during a burst updates the last-accessed location, the terminating zero count included. A later burst therefore continues right after the previous burst's terminator.
- R12: While `ee_req` is high and `ee_ready` is low, the request, address and direction stay unchanged. Only one EEPROM transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | HAW | Host register offset (read and write) |
| host_wdata | input | HDW | Host write data |
| host_rdata | output | HDW | Register contents at `host_addr` (combinational) |
| ee_req | output | 1 | EEPROM transaction request, held until ready |
| ee_we | output | 1 | Transaction direction: 1 for write |
| ee_addr | output | EE_AW | EEPROM byte location |
| ee_wdata | output | 8 | Byte to write |
| ee_rdata | input | 8 | Byte read, valid with `ee_ready` |
| ee_ready | input | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | BASE_W+OFS_W | Memory byte address |
| mem_data | output | 8 | Memory byte data |

## Verification
The checker watches several properties on every cycle:
- The request/ready handshake stays stable while a transaction is open.
- No EEPROM write happens during a burst.
- Each memory strobe follows a burst read completion.
- The upper memory address bits always equal the base register.
- At most one of the three operation modes is active, and the EEPROM is quiet whenever the block is idle.

Some properties only the bench scenarios can show. These are where a burst actually starts (after reset, after single accesses, after an earlier burst, and across the EEPROM wrap), the exact record parsing and offset wrap, the data values moved in both directions over every EEPROM location, and that host writes issued mid-operation leave the registers untouched.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SINGLE,
      S_CNT,
      S_ALO,
      S_AHI,
      S_DAT
   } seq_state_t;

   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_ADDR  = 1;
   localparam int unsigned REG_DATA  = 2;
   localparam int unsigned REG_BASE  = 3;
   localparam int unsigned REG_BURST = 4;

   localparam int unsigned CTRL_WR   = 0;
   localparam int unsigned CTRL_RD   = 1;
   localparam int unsigned CTRL_BUSY = 2;

endpackage

// File: rtl/eep_ptr.sv
module eep_ptr #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [AW-1:0] touch_addr,
   output logic [AW-1:0] next_from
);

   logic          seen_q;
   logic [AW-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (touch) begin
         seen_q <= 1'b1;
         last_q <= touch_addr;
      end
   end

   assign next_from = seen_q ? last_q + 1'b1 : '0;

endmodule

// File: rtl/eep_seq.sv
module eep_seq
   import eep_pkg::*;
#(
   parameter int unsigned EE_AW           = 16,
   parameter int unsigned OFS_W           = 15,
   parameter int unsigned BASE_W          = 9,
   parameter bit          CARRY_INTO_BASE = 1'b0,
   localparam int unsigned MAW            = BASE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_wr,
   input  logic              go_rd,
   input  logic              go_burst,
   input  logic [EE_AW-1:0]  single_addr,
   input  logic [EE_AW-1:0]  burst_from,
   input  logic [BASE_W-1:0] base,
   input  logic              ee_ready,
   input  logic [7:0]        ee_rdata,
   output logic              ee_req,
   output logic              ee_we,
   output logic [EE_AW-1:0]  ee_addr,
   output logic              rd_done,
   output logic              busy,
   output logic              single_wr,
   output logic              single_rd,
   output logic              burst_act,
   output logic              mem_we,
   output logic [MAW-1:0]    mem_addr,
   output logic [7:0]        mem_data
);

   seq_state_t         state;
   logic               op_wr;
   logic [EE_AW-1:0]   cur;
   logic [7:0]         cnt;
   logic [7:0]         lo;
   logic [MAW-1:0]     run_addr;
   logic [MAW-1:0]     run_next;
   logic [15:0]        hilo;
   logic               unused_hibit;

   assign hilo         = {ee_rdata, lo};
   assign unused_hibit = hilo[15];

   // the offset step either stays inside the offset field or ripples into the base
   generate
      if (CARRY_INTO_BASE) begin : g_carry
         assign run_next = run_addr + 1'b1;
      end else begin : g_wrap
         assign run_next = {run_addr[MAW-1:OFS_W], run_addr[OFS_W-1:0] + 1'b1};
      end
   endgenerate

   assign busy      = (state != S_IDLE);
   assign single_wr = (state == S_SINGLE) && op_wr;
   assign single_rd = (state == S_SINGLE) && !op_wr;
   assign burst_act = busy && (state != S_SINGLE);
   assign ee_req    = busy;
   assign ee_we     = single_wr;
   assign ee_addr   = (state == S_SINGLE) ? single_addr : cur;
   assign rd_done   = single_rd && ee_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_wr    <= 1'b0;
         cur      <= '0;
         cnt      <= '0;
         lo       <= '0;
         run_addr <= '0;
         mem_we   <= 1'b0;
         mem_addr <= '0;
         mem_data <= '0;
      end else begin
         mem_we <= 1'b0;
         case (state)
            S_IDLE: begin
               if (go_wr || go_rd) begin
                  state <= S_SINGLE;
                  op_wr <= go_wr;
               end else if (go_burst) begin
                  state <= S_CNT;
                  cur   <= burst_from;
               end
            end
            S_SINGLE: begin
               if (ee_ready) state <= S_IDLE;
            end
            S_CNT: begin
               if (ee_ready) begin
                  cur <= cur + 1'b1;
                  if (ee_rdata == 8'd0) begin
                     state <= S_IDLE;
                  end else begin
                     cnt   <= ee_rdata;
                     state <= S_ALO;
                  end
               end
            end
            S_ALO: begin
               if (ee_ready) begin
                  lo    <= ee_rdata;
                  cur   <= cur + 1'b1;
                  state <= S_AHI;
               end
            end
            S_AHI: begin
               if (ee_ready) begin
                  run_addr <= {base, hilo[OFS_W-1:0]};
                  cur      <= cur + 1'b1;
                  state    <= S_DAT;
               end
            end
            S_DAT: begin
               if (ee_ready) begin
                  mem_we   <= 1'b1;
                  mem_addr <= run_addr;
                  mem_data <= ee_rdata;
                  run_addr <= run_next;
                  cur      <= cur + 1'b1;
                  cnt      <= cnt - 1'b1;
                  if (cnt == 8'd1) state <= S_CNT;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eep_loader.sv
module eep_loader
   import eep_pkg::*;
#(
   parameter int unsigned EE_AW           = 16,
   parameter int unsigned OFS_W           = 15,
   parameter int unsigned BASE_W          = 9,
   parameter int unsigned HDW             = 32,
   parameter int unsigned HAW             = 3,
   parameter bit          CARRY_INTO_BASE = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_we,
   input  logic [HAW-1:0]          host_addr,
   input  logic [HDW-1:0]          host_wdata,
   output logic [HDW-1:0]          host_rdata,
   output logic                    ee_req,
   output logic                    ee_we,
   output logic [EE_AW-1:0]        ee_addr,
   output logic [7:0]              ee_wdata,
   input  logic [7:0]              ee_rdata,
   input  logic                    ee_ready,
   output logic                    mem_we,
   output logic [BASE_W+OFS_W-1:0] mem_addr,
   output logic [7:0]              mem_data
);

   generate
      if (OFS_W < 1 || OFS_W > 15) begin : g_bad_ofs
         $error("eep_loader: OFS_W must lie in 1..15");
      end
      if (BASE_W < 1) begin : g_bad_base
         $error("eep_loader: BASE_W must be at least 1");
      end
      if (HDW < 8 || HDW < EE_AW || HDW < BASE_W) begin : g_bad_hdw
         $error("eep_loader: HDW too narrow for the registers");
      end
      if (HAW < 3) begin : g_bad_haw
         $error("eep_loader: HAW must cover five offsets");
      end
   endgenerate

   logic [EE_AW-1:0]  addr_q;
   logic [7:0]        data_q;
   logic [BASE_W-1:0] base_q;
   logic              busy, single_wr, single_rd, burst_act, rd_done;
   logic              go_wr, go_rd, go_burst, wr_ok;
   logic [EE_AW-1:0]  burst_from;
   logic              unused_wdata;

   assign unused_wdata = ^host_wdata;
   assign wr_ok    = host_we && !busy;
   assign go_wr    = wr_ok && (host_addr == HAW'(REG_CTRL)) && host_wdata[CTRL_WR];
   assign go_rd    = wr_ok && (host_addr == HAW'(REG_CTRL)) && host_wdata[CTRL_RD]
                     && !host_wdata[CTRL_WR];
   assign go_burst = wr_ok && (host_addr == HAW'(REG_BURST)) && host_wdata[0];
   assign ee_wdata = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         base_q <= '0;
      end else begin
         if (rd_done) data_q <= ee_rdata;
         if (wr_ok) begin
            if (host_addr == HAW'(REG_ADDR)) addr_q <= host_wdata[EE_AW-1:0];
            if (host_addr == HAW'(REG_DATA)) data_q <= host_wdata[7:0];
            if (host_addr == HAW'(REG_BASE)) base_q <= host_wdata[BASE_W-1:0];
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == HAW'(REG_CTRL)) begin
         host_rdata[CTRL_WR]   = single_wr;
         host_rdata[CTRL_RD]   = single_rd;
         host_rdata[CTRL_BUSY] = busy;
      end else if (host_addr == HAW'(REG_ADDR)) begin
         host_rdata[EE_AW-1:0] = addr_q;
      end else if (host_addr == HAW'(REG_DATA)) begin
         host_rdata[7:0] = data_q;
      end else if (host_addr == HAW'(REG_BASE)) begin
         host_rdata[BASE_W-1:0] = base_q;
      end else if (host_addr == HAW'(REG_BURST)) begin
         host_rdata[0] = burst_act;
      end
   end

   eep_ptr #(.AW(EE_AW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (ee_req && ee_ready),
      .touch_addr(ee_addr),
      .next_from (burst_from)
   );

   eep_seq #(
      .EE_AW          (EE_AW),
      .OFS_W          (OFS_W),
      .BASE_W         (BASE_W),
      .CARRY_INTO_BASE(CARRY_INTO_BASE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_wr      (go_wr),
      .go_rd      (go_rd),
      .go_burst   (go_burst),
      .single_addr(addr_q),
      .burst_from (burst_from),
      .base       (base_q),
      .ee_ready   (ee_ready),
      .ee_rdata   (ee_rdata),
      .ee_req     (ee_req),
      .ee_we      (ee_we),
      .ee_addr    (ee_addr),
      .rd_done    (rd_done),
      .busy       (busy),
      .single_wr  (single_wr),
      .single_rd  (single_rd),
      .burst_act  (burst_act),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_data   (mem_data)
   );

endmodule

// File: rtl/eep_loader_chk.sv
module eep_loader_chk #(
   parameter int unsigned EE_AW           = 16,
   parameter int unsigned OFS_W           = 15,
   parameter int unsigned BASE_W          = 9,
   parameter bit          CARRY_INTO_BASE = 1'b0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ee_req,
   input logic                    ee_we,
   input logic [EE_AW-1:0]        ee_addr,
   input logic                    ee_ready,
   input logic                    mem_we,
   input logic [BASE_W+OFS_W-1:0] mem_addr,
   input logic [BASE_W-1:0]       base_q,
   input logic                    busy,
   input logic                    single_wr,
   input logic                    single_rd,
   input logic                    burst_act
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_req && !ee_ready) |=> (ee_req && $stable(ee_addr) && $stable(ee_we))); // R12

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ee_req); // R5

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({single_wr, single_rd, burst_act})); // R4

   AST_BURST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      burst_act |-> !ee_we); // R8

   AST_MEM_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(ee_ready) && $past(burst_act))); // R8

   AST_BURST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(burst_act) |-> !busy); // R6

   generate
      if (!CARRY_INTO_BASE) begin : g_base_chk
         AST_MEM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we |-> (mem_addr[BASE_W+OFS_W-1:OFS_W] == base_q)); // R10
      end
   endgenerate

endmodule

bind eep_loader eep_loader_chk #(
   .EE_AW          (EE_AW),
   .OFS_W          (OFS_W),
   .BASE_W         (BASE_W),
   .CARRY_INTO_BASE(CARRY_INTO_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ee_req   (ee_req),
   .ee_we    (ee_we),
   .ee_addr  (ee_addr),
   .ee_ready (ee_ready),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .base_q   (base_q),
   .busy     (busy),
   .single_wr(single_wr),
   .single_rd(single_rd),
   .burst_act(burst_act)
);

// File: tb/sim_eep_loader.sv
module sim_eep_loader;

   localparam int EAW = 8;
   localparam int MAW = 24;
   localparam int LAT = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            host_we = 1'b0;
   logic [2:0]      host_addr = '0;
   logic [31:0]     host_wdata = '0;
   logic [31:0]     host_rdata;
   logic            ee_req, ee_we;
   logic [EAW-1:0]  ee_addr;
   logic [7:0]      ee_wdata;
   logic [7:0]      ee_rdata = '0;
   logic            ee_ready = 1'b0;
   logic            mem_we;
   logic [MAW-1:0]  mem_addr;
   logic [7:0]      mem_data;

   logic [7:0]      eemem [0:255];
   logic            pre_we = 1'b0;
   logic [7:0]      pre_addr = '0;
   logic [7:0]      pre_data = '0;
   int              lcnt = 0;

   logic [MAW-1:0]  log_a [0:63];
   logic [7:0]      log_d [0:63];
   int              log_n = 0;
   logic            log_clr = 1'b0;

   int              exp_a [0:63];
   int              exp_d [0:63];
   int              exp_n = 0;

   int              checks = 0;
   int              errors = 0;

   always #10 clk = ~clk;

   eep_loader #(.EE_AW(EAW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
      .ee_rdata(ee_rdata), .ee_ready(ee_ready),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   // behavioural EEPROM: fixed latency, one-cycle ready pulse
   always @(posedge clk) begin
      ee_ready <= 1'b0;
      if (pre_we) eemem[pre_addr] <= pre_data;
      if (!rst_n) begin
         lcnt <= 0;
      end else if (!ee_ready) begin
         if (lcnt == 0) begin
            if (ee_req) lcnt <= LAT;
         end else if (lcnt == 1) begin
            ee_ready <= 1'b1;
            ee_rdata <= eemem[ee_addr];
            if (ee_we) eemem[ee_addr] <= ee_wdata;
            lcnt <= 0;
         end else begin
            lcnt <= lcnt - 1;
         end
      end
   end

   always @(posedge clk) begin
      if (log_clr) log_n <= 0;
      else if (mem_we && log_n < 64) begin
         log_a[log_n] <= mem_addr;
         log_d[log_n] <= mem_data;
         log_n <= log_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hw(input int a, input int d);
      @(negedge clk);
      host_we = 1'b1; host_addr = 3'(a); host_wdata = 32'(d);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hr(input int a, output int d);
      host_addr = 3'(a);
      #1;
      d = int'(host_rdata);
   endtask

   task automatic wait_idle();
      int v;
      for (int i = 0; i < 5000; i++) begin
         hr(0, v);
         if (v[2] == 1'b0) break;
         @(negedge clk);
      end
   endtask

   task automatic put(input int a, input int d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 8'(a); pre_data = 8'(d);
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic put_rec(input int at, input int cnt, input int lo, input int hi, input int d0);
      put(at, cnt); put(at + 1, lo); put(at + 2, hi);
      for (int i = 0; i < cnt; i++) put(at + 3 + i, (d0 + i) & 255);
   endtask

   task automatic add_exp(input int base, input int ofs, input int cnt, input int d0);
      for (int i = 0; i < cnt; i++) begin
         exp_a[exp_n] = (base << 15) | ((ofs + i) & 32'h7FFF);
         exp_d[exp_n] = (d0 + i) & 255;
         exp_n++;
      end
   endtask

   task automatic start_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
      exp_n = 0;
   endtask

   task automatic cmp_log(input string req);
      check(log_n == exp_n, req, log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         check(int'(log_a[i]) == exp_a[i], req, log_a[i], exp_a[i]);
         check(int'(log_d[i]) == exp_d[i], req, log_d[i], exp_d[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v;
      for (int i = 0; i < 256; i++) eemem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of every register and of the outward strobes
      for (int r = 0; r < 8; r++) begin
         hr(r, v);
         check(v == 0, "R1", v, 0);
      end
      check(ee_req == 1'b0, "R1", ee_req, 0);
      check(mem_we == 1'b0, "R1", mem_we, 0);

      // first burst, nothing touched yet: begins at location 0 (R7)
      put_rec(0, 3, 8'h10, 8'h81, 8'hA1);   // offset-high bit 7 must be dropped (R9)
      put_rec(6, 3, 8'hFE, 8'h7F, 8'hB1);   // offset wraps past 0x7FFF (R10)
      put(12, 0);
      start_log();
      add_exp(9'h1A5, 16'h0110, 3, 8'hA1);
      add_exp(9'h1A5, 16'h7FFE, 3, 8'hB1);
      hw(3, 9'h1A5);
      hw(4, 1);
      hr(4, v); check(v == 1, "R6", v, 1);
      hr(0, v); check(v == 4, "R5", v, 4);
      hw(3, 0);      // ignored while busy (R5)
      hw(0, 2);      // ignored while busy (R5)
      wait_idle();
      hr(4, v); check(v == 0, "R6", v, 0);
      hr(3, v); check(v == 9'h1A5, "R5", v, 9'h1A5);
      cmp_log("R8");

      // second burst continues after the terminator at 12 (R11)
      put_rec(13, 1, 8'h34, 8'h12, 8'hC1);
      put(17, 0);
      hw(3, 3);
      start_log();
      add_exp(3, 16'h1234, 1, 8'hC1);
      hw(4, 1);
      wait_idle();
      cmp_log("R11");

      // single-byte writes across the whole EEPROM (R2)
      for (int a = 0; a < 256; a++) begin
         hw(1, a);
         hw(2, 32'h55AA0000 | ((a * 5 + 7) & 255));
         hw(0, 1);
         if (a == 0) begin
            hr(0, v); check(v == 5, "R2", v, 5);
         end
         wait_idle();
         hr(0, v); check(v == 0, "R2", v, 0);
         check(int'(eemem[a]) == ((a * 5 + 7) & 255), "R2", eemem[a], (a * 5 + 7) & 255);
      end

      // single-byte reads across the whole EEPROM (R3)
      for (int a = 0; a < 256; a++) begin
         hw(2, 0);
         hw(1, a);
         hw(0, 2);
         if (a == 0) begin
            hr(0, v); check(v == 6, "R3", v, 6);
         end
         wait_idle();
         hr(2, v); check(v == ((a * 5 + 7) & 255), "R3", v, (a * 5 + 7) & 255);
      end

      // last access was 0xFF: next burst wraps to location 0 (R7)
      put_rec(0, 2, 8'h00, 8'h40, 8'hD1);
      put(5, 0);
      start_log();
      add_exp(3, 16'h4000, 2, 8'hD1);
      hw(4, 1);
      wait_idle();
      cmp_log("R7");

      // single read at 0x80 moves the burst start to 0x81 (R7)
      hw(1, 8'h80);
      hw(0, 2);
      wait_idle();
      put_rec(8'h81, 1, 8'h05, 8'h00, 8'hE1);
      put(8'h85, 0);
      start_log();
      add_exp(3, 16'h0005, 1, 8'hE1);
      hw(4, 1);
      wait_idle();
      cmp_log("R7");

      // both request bits together: write only (R4)
      put(8'h40, 8'h11);
      hw(1, 8'h40);
      hw(2, 8'h5A);
      hw(0, 3);
      hr(0, v); check(v == 5, "R4", v, 5);
      wait_idle();
      check(eemem[8'h40] == 8'h5A, "R4", eemem[8'h40], 8'h5A);
      hr(2, v); check(v == 8'h5A, "R4", v, 8'h5A);

      // register writes during a single read are dropped (R5)
      hw(1, 8'h20);
      hw(0, 2);
      hw(1, 8'h21);
      hw(2, 8'h99);
      wait_idle();
      hr(1, v); check(v == 8'h20, "R5", v, 8'h20);
      hr(2, v); check(v == ((32 * 5 + 7) & 255), "R3", v, (32 * 5 + 7) & 255);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule